// File: doc/BRIEF.md
# Serial Latch-Addressed Configuration Interface

This block receives configuration words over a three-wire serial link (data, shift clock, load strobe) and routes each completed 24-bit word into one of four internal 22-bit registers. All three serial lines are synchronised into the system clock domain and their rising edges are detected there. Each shift-clock edge moves one data bit into a shift register, most significant bit first. Each load-strobe edge hands the upper 22 bits of that register to the destination named by its two lowest bits.

Each register write raises a one-cycle strobe for that register. The strobe of the divider-N register also serves as the band-select start pulse for the synthesizer. The divide-by-2 enable is brought out separately. The block watches the first writes after reset and flags a divider-N write that arrives before both the divider-R and control registers have been written. It also flags any write to the factory test register. The most significant bit of the shift register is driven back out as a serial readback line.

Top module: `serial_cfg_if`

## Requirements
- R1: Serial data is taken on each rising edge of the shift clock and enters at bit 0, so the first bit sent ends up as word bit 23 (MSB first).
- R2: On a rising edge of the load strobe, word bits 23..2 are copied into the register chosen by word bits 1..0: 00 control, 01 divider-R, 10 divider-N, 11 test.
- R3: A register that is not addressed by a load keeps its value.
- R4: Each load raises exactly one bit of `wr_stb` (bit index = address code) for one cycle. It is due SYNC_STAGES+1 clock cycles after the load strobe rises at the pin, in the same cycle as the new register value. `band_sel_go` pulses together with the divider-N strobe.
- R5: `div2_en` equals bit 22 of the last word loaded into the divider-N register (bit 20 of `ndiv_q`).
- R6: `ser_rb` shows shift-register bit 23, so while a new word is shifted in, the previous word comes out MSB first.
- R7: `seq_err` is set when the divider-N register is loaded before both the divider-R and the control register have been loaded since reset. It stays set until reset.
- R8: A divider-N load after both the divider-R and control registers have been loaded leaves `seq_err` low.
- R9: A load to the test register updates `test_q` and sets `test_warn`, which stays set until reset.
- R10: After reset, all four registers, `wr_stb`, `band_sel_go`, `div2_en`, `seq_err`, `test_warn` and `ser_rb` are zero.
- R11: Holding the load strobe high makes no further load, even while new bits are shifted in. Its falling edge makes no load either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_dat | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_le | input | 1 | Load strobe |
| ctrl_q | output | 22 | Control register contents |
| rdiv_q | output | 22 | Divider-R register contents |
| ndiv_q | output | 22 | Divider-N register contents |
| test_q | output | 22 | Test register contents |
| wr_stb | output | 4 | One-cycle write strobe per register |
| band_sel_go | output | 1 | Band-select start pulse (divider-N write) |
| div2_en | output | 1 | Divide-by-2 enable from the divider-N register |
| seq_err | output | 1 | Sticky power-up order violation flag |
| test_warn | output | 1 | Sticky test-register write flag |
| ser_rb | output | 1 | Serial readback of shift-register MSB |

## Verification
A register value and its strobe are due SYNC_STAGES+1 clock edges after the load strobe rises at the pin. The sticky flags follow one edge later, and the readback bit settles SYNC_STAGES+1 edges after a shift-clock rise. The driver stamps each load with the current cycle count and queues the expected address and payload. The monitor pops an entry on every strobe and requires the exact latency as well as the register contents. Flags and readback are sampled only after the serial lines have been held for more than the synchroniser depth plus one cycle, so every check falls after the result is due.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned NUM_LATCH = 1 << SEL_W;

   typedef enum logic [SEL_W-1:0] {
      SEL_CTRL = 2'b00,
      SEL_RDIV = 2'b01,
      SEL_NDIV = 2'b10,
      SEL_TEST = 2'b11
   } latch_sel_e;

   localparam int unsigned IDX_CTRL = 0;
   localparam int unsigned IDX_RDIV = 1;
   localparam int unsigned IDX_NDIV = 2;
   localparam int unsigned IDX_TEST = 3;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES > 8) begin : g_bad_depth
      $error("cfg_sync: STAGES must not exceed 8");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
               chain[i] <= chain[i-1];
            end
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   output logic [WORD_W-1:0] word,
   output logic              rb
);
   logic sclk_prev;
   logic shift_en;

   assign shift_en = sclk_s & ~sclk_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         word      <= '0;
      end else begin
         sclk_prev <= sclk_s;
         if (shift_en) begin
            word <= {word[WORD_W-2:0], sdat_s};
         end
      end
   end

   assign rb = word[WORD_W-1];

   // R1: the word only moves on a detected shift-clock edge
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word));
   // R1: a shift-clock edge can never be seen in two consecutive cycles
   p_edge_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> !shift_en);
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
   import cfg_pkg::*;
#(
   parameter int unsigned        WORD_W    = 24,
   parameter int unsigned        PAY_W     = WORD_W - SEL_W,
   parameter logic [PAY_W-1:0]   LATCH_RST = '0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                le_s,
   input  logic [WORD_W-1:0]                   word,
   output logic [NUM_LATCH-1:0][PAY_W-1:0]     lat_q,
   output logic [NUM_LATCH-1:0]                wr_stb
);
   logic             le_prev;
   logic             load;
   logic [SEL_W-1:0] sel;
   logic [PAY_W-1:0] payload;

   assign load    = le_s & ~le_prev;
   assign sel     = word[SEL_W-1:0];
   assign payload = word[WORD_W-1:SEL_W];

   always_ff @(posedge clk) begin
      if (!rst_n) le_prev <= 1'b0;
      else        le_prev <= le_s;
   end

   for (genvar k = 0; k < int'(NUM_LATCH); k++) begin : g_latch
      logic hit;
      assign hit = load && (sel == SEL_W'(k));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lat_q[k]  <= LATCH_RST;
            wr_stb[k] <= 1'b0;
         end else begin
            wr_stb[k] <= hit;
            if (hit) lat_q[k] <= payload;
         end
      end

      // R3: a register without a strobe keeps its contents
      p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_stb[k] |-> $stable(lat_q[k]));
      // R2: a strobed register holds the upper bits of the word present before the edge
      p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
         wr_stb[k] |-> lat_q[k] == $past(word[WORD_W-1:SEL_W]));
   end

   // R4: at most one strobe at a time
   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_stb));
   // R4, R11: strobes last one cycle, a held strobe line makes no second load
   p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_stb) |=> (wr_stb == '0));
endmodule

// File: rtl/cfg_order_chk.sv
module cfg_order_chk
   import cfg_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LATCH-1:0] wr_stb,
   output logic                 seq_err,
   output logic                 test_warn
);
   logic rdiv_seen;
   logic ctrl_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdiv_seen <= 1'b0;
         ctrl_seen <= 1'b0;
         seq_err   <= 1'b0;
         test_warn <= 1'b0;
      end else begin
         if (wr_stb[IDX_RDIV]) rdiv_seen <= 1'b1;
         if (wr_stb[IDX_CTRL]) ctrl_seen <= 1'b1;
         if (wr_stb[IDX_NDIV] && !(rdiv_seen && ctrl_seen)) seq_err <= 1'b1;
         if (wr_stb[IDX_TEST]) test_warn <= 1'b1;
      end
   end

   // R7: the order flag never clears without reset
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);
   // R7: the order flag only rises right after a divider-N strobe
   p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> $past(wr_stb[IDX_NDIV]));
   // R9: the test flag never clears without reset
   p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      test_warn |=> test_warn);
   // R9: the test flag only rises right after a test strobe
   p_warn_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_warn) |-> $past(wr_stb[IDX_TEST]));
endmodule

// File: rtl/serial_cfg_if.sv
module serial_cfg_if
   import cfg_pkg::*;
#(
   parameter int unsigned      WORD_W      = 24,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter int unsigned      DIV2_BIT    = 22,
   parameter int unsigned      PAY_W       = WORD_W - SEL_W,
   parameter logic [PAY_W-1:0] LATCH_RST   = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ser_dat,
   input  logic                 ser_clk,
   input  logic                 ser_le,
   output logic [PAY_W-1:0]     ctrl_q,
   output logic [PAY_W-1:0]     rdiv_q,
   output logic [PAY_W-1:0]     ndiv_q,
   output logic [PAY_W-1:0]     test_q,
   output logic [NUM_LATCH-1:0] wr_stb,
   output logic                 band_sel_go,
   output logic                 div2_en,
   output logic                 seq_err,
   output logic                 test_warn,
   output logic                 ser_rb
);
   localparam int unsigned DIV2_PAY = DIV2_BIT - SEL_W;

   if (WORD_W < 8 || WORD_W > 64) begin : g_bad_word
      $error("serial_cfg_if: WORD_W must lie in 8..64");
   end
   if (PAY_W != WORD_W - SEL_W) begin : g_bad_pay
      $error("serial_cfg_if: PAY_W must equal WORD_W minus the address width");
   end
   if (DIV2_BIT < SEL_W || DIV2_BIT >= WORD_W) begin : g_bad_div2
      $error("serial_cfg_if: DIV2_BIT must sit in the payload field");
   end

   logic [2:0]                      pins_s;
   logic [WORD_W-1:0]               word;
   logic [NUM_LATCH-1:0][PAY_W-1:0] lat_q;

   cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_le, ser_clk, ser_dat}),
      .q    (pins_s)
   );

   cfg_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .sclk_s(pins_s[1]),
      .sdat_s(pins_s[0]),
      .word  (word),
      .rb    (ser_rb)
   );

   cfg_latch_bank #(.WORD_W(WORD_W), .PAY_W(PAY_W), .LATCH_RST(LATCH_RST)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .le_s  (pins_s[2]),
      .word  (word),
      .lat_q (lat_q),
      .wr_stb(wr_stb)
   );

   cfg_order_chk u_order (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .seq_err  (seq_err),
      .test_warn(test_warn)
   );

   assign ctrl_q      = lat_q[IDX_CTRL];
   assign rdiv_q      = lat_q[IDX_RDIV];
   assign ndiv_q      = lat_q[IDX_NDIV];
   assign test_q      = lat_q[IDX_TEST];
   assign band_sel_go = wr_stb[IDX_NDIV];
   assign div2_en     = ndiv_q[DIV2_PAY];

   // R5: the divide-by-2 enable only changes on a divider-N load
   p_div2_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb[IDX_NDIV] |-> $stable(div2_en));
   // R4: the band-select pulse is a single cycle
   p_band_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      band_sel_go |=> !band_sel_go);
endmodule

// File: tb/serial_cfg_if_tb_top.sv
module serial_cfg_if_tb_top;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_dat = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_le = 1'b0;
   logic [21:0] ctrl_q, rdiv_q, ndiv_q, test_q;
   logic [3:0]  wr_stb;
   logic        band_sel_go, div2_en, seq_err, test_warn, ser_rb;

   always #4 clk = ~clk;

   serial_cfg_if #(.SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_le(ser_le),
      .ctrl_q(ctrl_q), .rdiv_q(rdiv_q), .ndiv_q(ndiv_q), .test_q(test_q),
      .wr_stb(wr_stb), .band_sel_go(band_sel_go), .div2_en(div2_en),
      .seq_err(seq_err), .test_warn(test_warn), .ser_rb(ser_rb)
   );

   typedef struct {
      int unsigned sel;
      logic [21:0] pay;
      longint      stamp;
   } exp_t;

   exp_t        exp_q[$];
   logic [21:0] mdl[4];
   logic [23:0] last_word;
   longint      cyc = 0;
   int          n_tests = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   function automatic logic [21:0] reg_of(input int unsigned s);
      case (s)
         0: return ctrl_q;
         1: return rdiv_q;
         2: return ndiv_q;
         default: return test_q;
      endcase
   endfunction

   // Monitor: pops one expected load for each strobe seen
   always @(negedge clk) begin
      if (rst_n && wr_stb != 4'b0) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R11 unexpected strobe", {28'b0, wr_stb}, 32'h0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(wr_stb == (4'b1 << e.sel), "R4 strobe bit", {28'b0, wr_stb}, 32'(4'b1 << e.sel));
            chk(cyc - e.stamp == SYNC + 1, "R4 strobe latency", 32'(cyc - e.stamp), 32'(SYNC + 1));
            chk(band_sel_go == (e.sel == 2), "R4 band select pulse", {31'b0, band_sel_go}, {31'b0, e.sel == 2});
            chk(reg_of(e.sel) == e.pay, "R2 loaded value", {10'b0, reg_of(e.sel)}, {10'b0, e.pay});
         end
      end
   end

   task automatic shift_word(input logic [23:0] w);
      logic [23:0] rb;
      for (int i = 23; i >= 0; i--) begin
         @(negedge clk);
         rb[i] = ser_rb;
         ser_dat = w[i];
         repeat (3) @(negedge clk);
         ser_clk = 1'b1;
         repeat (3) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk(rb == last_word, "R6 readback of previous word", {8'b0, rb}, {8'b0, last_word});
      last_word = w;
   endtask

   task automatic raise_le(input int unsigned sel, input logic [21:0] pay);
      exp_t e;
      @(negedge clk);
      ser_le = 1'b1;
      e.sel = sel; e.pay = pay; e.stamp = cyc;
      exp_q.push_back(e);
      mdl[sel] = pay;
   endtask

   task automatic write_word(input int unsigned sel, input logic [21:0] pay);
      shift_word({pay, sel[1:0]});
      raise_le(sel, pay);
      repeat (6) @(negedge clk);
      ser_le = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic check_regs(input string req);
      for (int s = 0; s < 4; s++) begin
         chk(reg_of(s) == mdl[s], req, {10'b0, reg_of(s)}, {10'b0, mdl[s]});
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ser_dat = 1'b0; ser_clk = 1'b0; ser_le = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      last_word = '0;
      for (int s = 0; s < 4; s++) mdl[s] = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic check_reset_state();
      check_regs("R10 register reset");
      chk(wr_stb == 4'b0 && !band_sel_go, "R10 strobes idle", {28'b0, wr_stb}, 32'h0);
      chk({div2_en, seq_err, test_warn, ser_rb} == 4'b0, "R10 flags clear",
          {28'b0, div2_en, seq_err, test_warn, ser_rb}, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      check_reset_state();

      // Wrong order: divider-R, then divider-N before control
      write_word(1, 22'h2AAAAA);
      check_regs("R3 others unchanged after R load");
      chk(!seq_err, "R7 no flag after R load alone", {31'b0, seq_err}, 32'h0);
      write_word(2, 22'h155555);
      chk(seq_err, "R7 N before control flags error", {31'b0, seq_err}, 32'h1);
      chk(div2_en, "R5 div2 from word bit 22", {31'b0, div2_en}, 32'h1);
      check_regs("R3 others unchanged after N load");
      write_word(0, 22'h3C0F0F);
      chk(seq_err, "R7 flag sticky after later loads", {31'b0, seq_err}, 32'h1);
      chk(!test_warn, "R9 no test flag without test load", {31'b0, test_warn}, 32'h0);

      // Reset clears everything again
      do_reset();
      check_reset_state();

      // Correct order (control and divider-R both before N)
      write_word(0, 22'h000001);
      write_word(1, 22'h3FFFFF);
      write_word(2, 22'h0ABCDE);
      chk(!seq_err, "R8 legal order leaves flag low", {31'b0, seq_err}, 32'h0);
      chk(!div2_en, "R5 div2 clear with bit 22 low", {31'b0, div2_en}, 32'h0);
      write_word(2, 22'h100000);
      chk(div2_en, "R5 div2 set by later N load", {31'b0, div2_en}, 32'h1);
      chk(ndiv_q == 22'h100000, "R1 MSB-first word assembly", {10'b0, ndiv_q}, 32'h100000);
      write_word(2, 22'h0FFFFF);
      chk(!div2_en, "R5 div2 cleared again", {31'b0, div2_en}, 32'h0);

      // Test register load
      write_word(3, 22'h1E0F33);
      chk(test_warn, "R9 test load raises warning", {31'b0, test_warn}, 32'h1);
      chk(test_q == 22'h1E0F33, "R9 test register accepted", {10'b0, test_q}, 32'h1E0F33);
      write_word(1, 22'h0000AA);
      chk(test_warn, "R9 warning sticky", {31'b0, test_warn}, 32'h1);
      check_regs("R3 all registers match model");

      // Held strobe: one load at the rise, nothing while shifting or at the fall
      shift_word({22'h2468AC, 2'b00});
      raise_le(0, 22'h2468AC);
      repeat (6) @(negedge clk);
      shift_word({22'h13579B, 2'b01});
      repeat (4) @(negedge clk);
      ser_le = 1'b0;
      repeat (8) @(negedge clk);
      chk(exp_q.size() == 0, "R11 expected loads all seen", 32'(exp_q.size()), 32'h0);
      check_regs("R11 no load from held or falling strobe");
      chk(!seq_err, "R8 flag still low", {31'b0, seq_err}, 32'h0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule